// File: doc/BRIEF.md
# Three-Core MESI Coherence Tracker

This block follows the coherence state of a single cache line held by three private caches that snoop a shared bus. It takes in one memory reference at a time. Each reference names a core, says whether it is a read or a write, and says which of two words inside the line it touches. For each reference the block moves all three cache states to their next MESI values. It also reports the bus transaction that the reference caused, whether it found a valid local copy, and how many cycles it costs. A running cycle total is kept as well.

Coherence is tracked for the whole line, not per word. A write to one word therefore invalidates peer copies that were only ever used for the other word. The block flags these false-sharing invalidations. Costs come from four levels: a local hit, an invalidate-only broadcast, a line supplied by a peer cache, and a line fetched from memory. The line is never evicted.

References arrive on a valid/ready input. `ref_ready` is low during reset and stays high from the first clock after reset. A reference is accepted on every rising edge where `ref_valid` and `ref_ready` are both high. The block applies no back-pressure after reset. The result side has no ready: `res_valid` pulses for one cycle, and the result fields hold their last value until the next accepted reference.

Top module: `mesi_tracker`

## Requirements
- R1: While synchronous reset `rst` is high, every cache state reads Invalid (code 0), `res_total` is 0, `res_valid` is 0 and `ref_ready` is 0. `ref_ready` is 1 from the first clock after reset is released. State codes are I=0, S=1, E=2, M=3. Cache k sits in `res_state[2k+1:2k]`.
- R2: A reference accepted at a rising edge gives `res_valid`=1 for exactly the following cycle. In a cycle with no accepted reference, no state and no total changes. Bus codes are NONE=0, BUSRD=1, BUSRDX=2, BUSUPGR=3.
- R3: A read from a core in Invalid when no peer holds a valid copy issues BUSRD, costs 150, installs the line in E and reports `res_hit`=0.
- R4: A read from a core in Invalid when a peer holds a valid copy issues BUSRD and costs 50. The requester goes to S, and every peer in M or E drops to S.
- R5: A read from a core in S, E or M issues NONE, costs 1, reports `res_hit`=1 and changes no state.
- R6: A write from a core in E moves it to M silently (NONE, cost 1, hit). A write from a core in M is a plain hit (NONE, cost 1).
- R7: A write from a core in S issues BUSUPGR, costs 10, reports `res_hit`=1, moves the writer to M and every peer to Invalid.
- R8: A write from a core in Invalid issues BUSRDX and reports `res_hit`=0. It costs 50 if a peer holds a valid copy and 150 otherwise. The writer goes to M and every peer goes to Invalid.
- R9: On each result, `res_total` rises by `res_cost`, modulo 2^32.
- R10: `res_false_share` is 1 when a write invalidates at least one valid peer copy whose last reference from that peer was to the other word (`ref_word` 0 = word A, 1 = word B). Otherwise it is 0.
- R11: A reference with `ref_proc`=3 is accepted but discarded. It produces no `res_valid` and changes no state and no total.
- R12: Whenever any cache is in M or E, no other cache holds a valid copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference offered |
| ref_ready | output | 1 | Reference can be taken |
| ref_is_write | input | 1 | 1 = write, 0 = read |
| ref_proc | input | 2 | Requesting core, 0 to 2 (3 is dropped) |
| ref_word | input | 1 | Word within the line, 0 = A, 1 = B |
| res_valid | output | 1 | One-cycle result strobe |
| res_state | output | 6 | Two-bit MESI state per cache |
| res_bus | output | 2 | Bus transaction of the last reference |
| res_hit | output | 1 | Requester already held a valid copy |
| res_cost | output | 8 | Cycle cost of the last reference |
| res_false_share | output | 1 | Last write killed a copy used for the other word |
| res_total | output | 32 | Running cycle total |

## Verification
The assertions assume that `rst` is high at the first rising edge, and that `ref_is_write`, `ref_proc` and `ref_word` are known values whenever `ref_valid` is high. The bench drives every input on the falling edge. It holds reset over the first edges and keeps the fields defined whenever it raises `ref_valid`. It drops `ref_valid` after one cycle, so each reference is accepted exactly once. It samples results at the next falling edge.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {BUS_NONE = 2'd0, BUS_RD = 2'd1, BUS_RDX = 2'd2, BUS_UPGR = 2'd3} bus_t;
endpackage

// File: rtl/mesi_snoop.sv
`timescale 1ns/1ps
// Reaction of a non-requesting cache to the transaction seen on the bus.
module mesi_snoop
  import mesi_pkg::*;
(
  input  mesi_t cur,
  input  bus_t  bus,
  output mesi_t nxt
);
  always_comb begin
    nxt = cur;
    unique case (bus)
      BUS_RD:   if (cur == ST_M || cur == ST_E) nxt = ST_S;
      BUS_RDX,
      BUS_UPGR: nxt = ST_I;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/mesi_decide.sv
`timescale 1ns/1ps
// Requester-side decision: bus transaction, hit, cost and own next state.
module mesi_decide
  import mesi_pkg::*;
#(
  parameter int COST_HIT  = 1,
  parameter int COST_UPGR = 10,
  parameter int COST_PEER = 50,
  parameter int COST_MEM  = 150,
  localparam int COST_W   = $clog2(COST_MEM + 1)
) (
  input  mesi_t             own,
  input  logic              is_write,
  input  logic              peer_valid,
  output bus_t              bus,
  output logic              hit,
  output logic [COST_W-1:0] cost,
  output mesi_t             own_nxt
);
  logic [COST_W-1:0] fill_cost;
  assign fill_cost = peer_valid ? COST_W'(COST_PEER) : COST_W'(COST_MEM);

  always_comb begin
    bus     = BUS_NONE;
    hit     = (own != ST_I);
    cost    = COST_W'(COST_HIT);
    own_nxt = own;
    if (!is_write) begin
      if (own == ST_I) begin
        bus     = BUS_RD;
        cost    = fill_cost;
        own_nxt = peer_valid ? ST_S : ST_E;
      end
    end else begin
      unique case (own)
        ST_E: own_nxt = ST_M;
        ST_S: begin
          bus     = BUS_UPGR;
          cost    = COST_W'(COST_UPGR);
          own_nxt = ST_M;
        end
        ST_I: begin
          bus     = BUS_RDX;
          cost    = fill_cost;
          own_nxt = ST_M;
        end
        default: own_nxt = ST_M;
      endcase
    end
  end

  // R3 R8: memory cost only ever pairs with a miss
  always_comb begin
    if (own != ST_I)
      assert_valid_no_fill_R3: assert (cost <= COST_W'(COST_UPGR));
  end
endmodule

// File: rtl/mesi_tracker.sv
`timescale 1ns/1ps
module mesi_tracker
  import mesi_pkg::*;
#(
  parameter int NCORE     = 3,
  parameter int COST_HIT  = 1,
  parameter int COST_UPGR = 10,
  parameter int COST_PEER = 50,
  parameter int COST_MEM  = 150,
  parameter int TOTAL_W   = 32,
  localparam int PROC_W   = $clog2(NCORE),
  localparam int COST_W   = $clog2(COST_MEM + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_valid,
  output logic                 ref_ready,
  input  logic                 ref_is_write,
  input  logic [PROC_W-1:0]    ref_proc,
  input  logic                 ref_word,
  output logic                 res_valid,
  output logic [2*NCORE-1:0]   res_state,
  output logic [1:0]           res_bus,
  output logic                 res_hit,
  output logic [COST_W-1:0]    res_cost,
  output logic                 res_false_share,
  output logic [TOTAL_W-1:0]   res_total
);
  mesi_t             st_q [NCORE];
  mesi_t             snoop_nxt [NCORE];
  logic [NCORE-1:0]  last_word_q;
  logic [NCORE-1:0]  is_req, valid_v, owner_v, remote_v, stale_v;
  logic              ready_q, take;
  mesi_t             own_st, own_nxt;
  bus_t              bus_d, bus_q;
  logic              hit_d;
  logic [COST_W-1:0] cost_d;
  logic              fs_d;

  assign take = ref_valid && ready_q && (int'(ref_proc) < NCORE);

  for (genvar i = 0; i < NCORE; i++) begin : g_cache
    assign is_req[i]   = (ref_proc == PROC_W'(i));
    assign valid_v[i]  = (st_q[i] != ST_I);
    assign owner_v[i]  = (st_q[i] == ST_E) || (st_q[i] == ST_M);
    assign remote_v[i] = valid_v[i] && !is_req[i];
    assign stale_v[i]  = remote_v[i] && (last_word_q[i] != ref_word);
    assign res_state[2*i +: 2] = st_q[i];
    mesi_snoop u_snoop (.cur(st_q[i]), .bus(bus_d), .nxt(snoop_nxt[i]));
  end

  always_comb begin
    own_st = ST_I;
    for (int i = 0; i < NCORE; i++)
      if (is_req[i]) own_st = st_q[i];
  end

  mesi_decide #(
    .COST_HIT(COST_HIT), .COST_UPGR(COST_UPGR),
    .COST_PEER(COST_PEER), .COST_MEM(COST_MEM)
  ) u_decide (
    .own(own_st), .is_write(ref_is_write), .peer_valid(|remote_v),
    .bus(bus_d), .hit(hit_d), .cost(cost_d), .own_nxt(own_nxt)
  );

  assign fs_d = ref_is_write && (bus_d == BUS_RDX || bus_d == BUS_UPGR) && (|stale_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCORE; i++) st_q[i] <= ST_I;
      last_word_q     <= '0;
      ready_q         <= 1'b0;
      res_valid       <= 1'b0;
      bus_q           <= BUS_NONE;
      res_hit         <= 1'b0;
      res_cost        <= '0;
      res_false_share <= 1'b0;
      res_total       <= '0;
    end else begin
      ready_q   <= 1'b1;
      res_valid <= take;
      if (take) begin
        for (int i = 0; i < NCORE; i++) begin
          st_q[i] <= is_req[i] ? own_nxt : snoop_nxt[i];
          if (is_req[i]) last_word_q[i] <= ref_word;
        end
        bus_q           <= bus_d;
        res_hit         <= hit_d;
        res_cost        <= cost_d;
        res_false_share <= fs_d;
        res_total       <= res_total + TOTAL_W'(cost_d);
      end
    end
  end

  assign ref_ready = ready_q;
  assign res_bus   = bus_q;

  // R12: an exclusive owner never coexists with another valid copy
  assert_single_owner_R12: assert property (@(posedge clk) disable iff (rst)
    (|owner_v) |-> ($countones(valid_v) == 1));
  // R9: total advances by exactly the reported cost
  assert_total_step_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_total == $past(res_total) + TOTAL_W'(res_cost)));
  // R2: without a result nothing moves
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_total) && $stable(res_state)));
  // R1: ready holds high once out of reset
  assert_ready_high_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ref_ready);
  // R7: an upgrade is a hit at the broadcast cost
  assert_upgr_cost_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_bus == BUS_UPGR) |-> (res_hit && res_cost == COST_W'(COST_UPGR)));
  // R5 R6: no bus traffic means a local hit at the hit cost
  assert_quiet_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_bus == BUS_NONE) |-> (res_hit && res_cost == COST_W'(COST_HIT)));
endmodule

// File: tb/sim_mesi_tracker.sv
`timescale 1ns/1ps
module sim_mesi_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_valid = 1'b0, ref_is_write = 1'b0, ref_word = 1'b0;
  logic [1:0]  ref_proc = 2'd0;
  logic        ref_ready, res_valid, res_hit, res_false_share;
  logic [5:0]  res_state;
  logic [1:0]  res_bus;
  logic [7:0]  res_cost;
  logic [31:0] res_total;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_total;

  always #10 clk = ~clk;

  mesi_tracker u0 (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_is_write(ref_is_write), .ref_proc(ref_proc), .ref_word(ref_word),
    .res_valid(res_valid), .res_state(res_state), .res_bus(res_bus),
    .res_hit(res_hit), .res_cost(res_cost), .res_false_share(res_false_share),
    .res_total(res_total)
  );

  // {wr, proc[1:0], word, state{c2,c1,c0}[5:0], bus[1:0], hit, cost[7:0], fs}
  localparam logic [21:0] VEC [10] = '{
    {1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd2, 2'd1, 1'b0, 8'd150, 1'b0},
    {1'b0, 2'd2, 1'b1, 2'd1, 2'd0, 2'd1, 2'd1, 1'b0, 8'd50,  1'b0},
    {1'b1, 2'd2, 1'b1, 2'd3, 2'd0, 2'd0, 2'd3, 1'b1, 8'd10,  1'b1},
    {1'b0, 2'd0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 1'b0, 8'd50,  1'b0},
    {1'b0, 2'd1, 1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 1'b0, 8'd50,  1'b0},
    {1'b1, 2'd0, 1'b1, 2'd0, 2'd0, 2'd3, 2'd3, 1'b1, 8'd10,  1'b1},
    {1'b0, 2'd1, 1'b1, 2'd0, 2'd1, 2'd1, 2'd1, 1'b0, 8'd50,  1'b0},
    {1'b1, 2'd0, 1'b1, 2'd0, 2'd0, 2'd3, 2'd3, 1'b1, 8'd10,  1'b0},
    {1'b1, 2'd2, 1'b0, 2'd3, 2'd0, 2'd0, 2'd2, 1'b0, 8'd50,  1'b1},
    {1'b0, 2'd0, 1'b0, 2'd1, 2'd0, 2'd1, 2'd1, 1'b0, 8'd50,  1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic w, input logic [1:0] p, input logic wd);
    @(negedge clk);
    ref_valid = 1'b1; ref_is_write = w; ref_proc = p; ref_word = wd;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ready in reset", 32'(ref_ready), 0);
    chk("R1", "state in reset", 32'(res_state), 0);
    chk("R1", "total in reset", res_total, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", 32'(ref_ready), 1);
    chk("R1", "valid after reset", 32'(res_valid), 0);
    exp_total = 0;
  endtask

  task automatic expect_res(input string req, input logic [5:0] st, input logic [1:0] bus,
                            input logic hit, input logic [7:0] cost, input logic fs);
    exp_total = exp_total + 32'(cost);
    chk(req, "valid", 32'(res_valid), 1);
    chk(req, "state", 32'(res_state), 32'(st));
    chk(req, "bus",   32'(res_bus), 32'(bus));
    chk(req, "hit",   32'(res_hit), 32'(hit));
    chk(req, "cost",  32'(res_cost), 32'(cost));
    chk("R10", "false share", 32'(res_false_share), 32'(fs));
    chk("R9", "total", res_total, exp_total);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // Two-word stream over one line: R3 R4 R7 R8 R10 R9
    for (int k = 0; k < 10; k++) begin
      send(VEC[k][21], VEC[k][20:19], VEC[k][18]);
      expect_res("R3/R4/R7/R8 stream", VEC[k][17:12], VEC[k][11:10], VEC[k][9], VEC[k][8:1], VEC[k][0]);
    end
    // Result pulse lasts one cycle: R2
    @(negedge clk);
    chk("R2", "pulse drop", 32'(res_valid), 0);
    chk("R2", "idle total", res_total, exp_total);

    do_reset();
    send(1'b0, 2'd1, 1'b0);                       // R3
    expect_res("R3", 6'b00_10_00, 2'd1, 1'b0, 8'd150, 1'b0);
    send(1'b1, 2'd1, 1'b1);                       // R6 silent E->M
    expect_res("R6", 6'b00_11_00, 2'd0, 1'b1, 8'd1, 1'b0);
    send(1'b1, 2'd1, 1'b1);                       // R6 M write hit
    expect_res("R6", 6'b00_11_00, 2'd0, 1'b1, 8'd1, 1'b0);
    send(1'b0, 2'd1, 1'b0);                       // R5 read hit in M
    expect_res("R5", 6'b00_11_00, 2'd0, 1'b1, 8'd1, 1'b0);
    send(1'b1, 2'd3, 1'b1);                       // R11 dropped
    chk("R11", "no result", 32'(res_valid), 0);
    chk("R11", "state kept", 32'(res_state), 32'(6'b00_11_00));
    chk("R11", "total kept", res_total, exp_total);
    repeat (3) @(negedge clk);                     // R2 idle
    chk("R2", "idle state", 32'(res_state), 32'(6'b00_11_00));
    chk("R2", "idle total", res_total, exp_total);
    send(1'b1, 2'd0, 1'b0);                       // R8 peer supply, same word: no false share
    expect_res("R8", 6'b00_00_11, 2'd2, 1'b0, 8'd50, 1'b0);
    send(1'b0, 2'd2, 1'b1);                       // R4 M peer downgraded
    expect_res("R4", 6'b01_00_01, 2'd1, 1'b0, 8'd50, 1'b0);
    send(1'b0, 2'd2, 1'b0);                       // R5 read hit in S
    expect_res("R5", 6'b01_00_01, 2'd0, 1'b1, 8'd1, 1'b0);

    do_reset();
    send(1'b1, 2'd2, 1'b0);                       // R8 from memory
    expect_res("R8", 6'b11_00_00, 2'd2, 1'b0, 8'd150, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule